// File: doc/BRIEF.md
# Multimodulus Prescaler Controller with Fractional Accumulator

This block steers an external prescaler that can divide by two, three or four different ratios. A single 12-bit counter advances on every prescaler output pulse. It first counts down through the R1 phase. It then counts up through the R2, R3 and R4 phases, and each of those phases ends when the counter's low bits reach a programmed cumulative target. Two modulus-control outputs tell the prescaler which ratio to apply. A one-clock pulse marks the end of each complete division cycle for the phase comparator.

A fractional accumulator with modulus 5 or 8 adds a 3-bit increment once per division cycle. When it overflows, the next division cycle is lengthened by one prescaler count: its first R1 step is replaced by an R2 step. The current accumulator value is brought out so that a ripple-compensation stage can use it.

The prescaler pulse is a one-clock strobe that is synchronous to `clk_i`. Configuration inputs are held steady while the block runs, and they are changed only while reset is asserted.

Top module: `mmdiv_ctrl`

## Requirements
- R1: After reset is released, the modulus outputs show R1 (MOD2=0, MOD1=1), `div_o` is low and `acc_o` is 0. The counter loads `n1_i` on the first clock after the synchronised reset release.
- R2: The modulus outputs use the encoding {MOD2,MOD1}: R1 = 01, R2 = 00, R3 = 10, R4 = 11. They change only in the clock after a sampled prescaler pulse.
- R3: Each division cycle starts with R1 selected for `n1_i` prescaler pulses, and then switches to R2.
- R4: In two-modulus mode (`nmod_i` = 00, or the undefined code 11), R2 lasts until the up-count equals the 8-bit `n2_i`. The cycle then restarts from R1, and `div_o` is high for one clock after the final pulse.
- R5: In three-modulus mode (`nmod_i` = 01), R2 ends when the low 4 bits of the count equal `n2_i[3:0]`. R3 then lasts until those 4 bits equal `sum3_i`, and the cycle ends.
- R6: In four-modulus mode (`nmod_i` = 10), after R3 the count continues with R4 until its low 4 bits equal `sum4_i`, and the cycle ends.
- R7: A 4-bit phase whose target equals its starting value lasts 16 pulses. This applies to `n2_i[3:0]` = 0, to `sum3_i` = `n2_i[3:0]` and to `sum4_i` = `sum3_i`.
- R8: At each cycle end, the accumulator adds `frac_inc_i` modulo Q, with Q = 5 when `frac_sel_i` = 0 and Q = 8 when it is 1. The result is reduced until it is below Q, and a wrap counts as one overflow.
- R9: An overflow is latched at the cycle end. The first R1 step of the next cycle then shows R2, so that cycle's total ratio rises by one.
- R10: `acc_o` changes only together with a division-cycle end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pulse_i | input | 1 | One-clock strobe per prescaler output cycle |
| n1_i | input | 12 | Number of R1 steps |
| n2_i | input | 8 | R2 target (8 bits in two-modulus mode, low 4 bits otherwise) |
| sum3_i | input | 4 | Cumulative R2+R3 target, modulo 16 |
| sum4_i | input | 4 | Cumulative R2+R3+R4 target, modulo 16 |
| nmod_i | input | 2 | Prescaler modulus count: 00 two, 01 three, 10 four, 11 two |
| frac_inc_i | input | 3 | Fractional increment |
| frac_sel_i | input | 1 | Accumulator modulus: 0 for 5, 1 for 8 |
| mod1_o | output | 1 | Modulus control bit 1 |
| mod2_o | output | 1 | Modulus control bit 2 |
| div_o | output | 1 | One-clock pulse after each complete division cycle |
| acc_o | output | 3 | Present accumulator value |

## Verification
The sequencer is exercised in these configurations:
- Two-modulus mode, reached through both its own code and the spare code, with short and 8-bit R2 counts. This separates the 8-bit compare from the 4-bit compare.
- Three-modulus and four-modulus mode. These show whether R3 and R4 are entered, skipped or ended in the right place.
- Zero-length R2 and R3 settings. These tell a 16-pulse phase apart from a phase that is skipped.

The fractional path is driven with:
- Modulus 8 and increment 3, checked against the known 3, 6, 1, 4, 7, 2, 5, 0 sequence.
- Modulus 5 with increment 2.
- Modulus 5 with increment 7, which needs a double reduction.

In every case a per-pulse model predicts the modulus code, where the cycle ends, and where the R1 step is replaced by R2.

// File: rtl/mmdiv_pkg.sv
package mmdiv_pkg;

  typedef enum logic [1:0] {
    PH_R1 = 2'd0,
    PH_R2 = 2'd1,
    PH_R3 = 2'd2,
    PH_R4 = 2'd3
  } phase_e;

  // {MOD2,MOD1} drive code for each prescaler ratio
  function automatic logic [1:0] ratio_code(phase_e ph);
    logic [1:0] c;
    case (ph)
      PH_R1:   c = 2'b01;
      PH_R2:   c = 2'b00;
      PH_R3:   c = 2'b10;
      default: c = 2'b11;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/mmdiv_rst_sync.sv
module mmdiv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/mmdiv_seq.sv
module mmdiv_seq
  import mmdiv_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int N2_W  = 8,
  parameter int SUM_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pulse_i,
  input  logic [CNT_W-1:0] n1_i,
  input  logic [N2_W-1:0]  n2_i,
  input  logic [SUM_W-1:0] sum3_i,
  input  logic [SUM_W-1:0] sum4_i,
  input  logic [1:0]       nmod_i,
  input  logic             ext_i,
  output logic [1:0]       code_o,
  output logic             r1_step_o,
  output logic             cyc_end_o
);
  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             load_q, load_d;
  logic             en;
  logic [CNT_W-1:0] inc;
  logic             mode_two, mode_three;
  logic             hit_r2, hit_r3, hit_r4;
  logic             last;

  assign mode_three = (nmod_i == 2'b01);
  assign mode_two   = (nmod_i == 2'b00) || (nmod_i == 2'b11);
  assign inc        = cnt_q + CNT_W'(1);

  // R2 target width depends on the number of moduli
  assign hit_r2 = mode_two ? (inc[N2_W-1:0] == n2_i)
                           : (inc[SUM_W-1:0] == n2_i[SUM_W-1:0]);
  assign hit_r3 = (inc[SUM_W-1:0] == sum3_i);
  assign hit_r4 = (inc[SUM_W-1:0] == sum4_i);

  always_comb begin
    cnt_d  = cnt_q;
    ph_d   = ph_q;
    load_d = load_q;
    last   = 1'b0;
    if (load_q) begin
      cnt_d  = n1_i;
      ph_d   = PH_R1;
      load_d = 1'b0;
    end else if (pulse_i) begin
      case (ph_q)
        PH_R1: begin
          cnt_d = cnt_q - CNT_W'(1);
          if (cnt_q == CNT_W'(1)) ph_d = PH_R2;
        end
        PH_R2: begin
          cnt_d = inc;
          if (hit_r2) begin
            if (mode_two) last = 1'b1;
            else          ph_d = PH_R3;
          end
        end
        PH_R3: begin
          cnt_d = inc;
          if (hit_r3) begin
            if (mode_three) last = 1'b1;
            else            ph_d = PH_R4;
          end
        end
        default: begin
          cnt_d = inc;
          if (hit_r4) last = 1'b1;
        end
      endcase
      if (last) begin
        cnt_d = n1_i;
        ph_d  = PH_R1;
      end
    end
  end

  assign en = load_q | pulse_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      ph_q   <= PH_R1;
      load_q <= 1'b1;
    end else if (en) begin
      cnt_q  <= cnt_d;
      ph_q   <= ph_d;
      load_q <= load_d;
    end
  end

  // pending N+1 turns the first R1 step into an R2 step
  assign code_o    = (ph_q == PH_R1 && ext_i) ? ratio_code(PH_R2) : ratio_code(ph_q);
  assign r1_step_o = pulse_i && !load_q && (ph_q == PH_R1);
  assign cyc_end_o = last;
endmodule

// File: rtl/mmdiv_frac.sv
module mmdiv_frac #(
  parameter int FRAC_W = 3,
  parameter int MOD_LO = 5,
  parameter int MOD_HI = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FRAC_W-1:0] inc_i,
  input  logic              sel_i,
  input  logic              cyc_end_i,
  input  logic              r1_step_i,
  output logic [FRAC_W-1:0] acc_o,
  output logic              ext_o
);
  localparam int SW = FRAC_W + 1;

  logic [FRAC_W-1:0] acc_q, acc_d;
  logic              ext_q, ext_d;
  logic [SW-1:0]     modv, sum, s1, s2;
  logic              ovf, en;

  assign modv = sel_i ? SW'(MOD_HI) : SW'(MOD_LO);
  assign sum  = SW'(acc_q) + SW'(inc_i);
  assign ovf  = (sum >= modv);
  assign s1   = ovf ? (sum - modv) : sum;
  assign s2   = (s1 >= modv) ? (s1 - modv) : s1;

  always_comb begin
    acc_d = acc_q;
    ext_d = ext_q;
    if (cyc_end_i) begin
      acc_d = s2[FRAC_W-1:0];
      ext_d = ovf;
    end else if (r1_step_i) begin
      ext_d = 1'b0;
    end
  end

  assign en = cyc_end_i | r1_step_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      ext_q <= 1'b0;
    end else if (en) begin
      acc_q <= acc_d;
      ext_q <= ext_d;
    end
  end

  assign acc_o = acc_q;
  assign ext_o = ext_q;
endmodule

// File: rtl/mmdiv_ctrl.sv
module mmdiv_ctrl #(
  parameter int CNT_W  = 12,
  parameter int N2_W   = 8,
  parameter int SUM_W  = 4,
  parameter int FRAC_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pulse_i,
  input  logic [CNT_W-1:0]  n1_i,
  input  logic [N2_W-1:0]   n2_i,
  input  logic [SUM_W-1:0]  sum3_i,
  input  logic [SUM_W-1:0]  sum4_i,
  input  logic [1:0]        nmod_i,
  input  logic [FRAC_W-1:0] frac_inc_i,
  input  logic              frac_sel_i,
  output logic              mod1_o,
  output logic              mod2_o,
  output logic              div_o,
  output logic [FRAC_W-1:0] acc_o
);
  logic       rst_sync_n;
  logic [1:0] code;
  logic       r1_step, cyc_end, ext;
  logic       div_q;

  mmdiv_rst_sync #(.STAGES(2)) u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_sync_n)
  );

  mmdiv_seq #(.CNT_W(CNT_W), .N2_W(N2_W), .SUM_W(SUM_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .pulse_i  (pulse_i),
    .n1_i     (n1_i),
    .n2_i     (n2_i),
    .sum3_i   (sum3_i),
    .sum4_i   (sum4_i),
    .nmod_i   (nmod_i),
    .ext_i    (ext),
    .code_o   (code),
    .r1_step_o(r1_step),
    .cyc_end_o(cyc_end)
  );

  mmdiv_frac #(.FRAC_W(FRAC_W)) u_frac (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .inc_i    (frac_inc_i),
    .sel_i    (frac_sel_i),
    .cyc_end_i(cyc_end),
    .r1_step_i(r1_step),
    .acc_o    (acc_o),
    .ext_o    (ext)
  );

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) div_q <= 1'b0;
    else             div_q <= cyc_end;
  end

  assign div_o  = div_q;
  assign mod2_o = code[1];
  assign mod1_o = code[0];
endmodule

// File: rtl/mmdiv_chk.sv
module mmdiv_chk #(
  parameter int FRAC_W = 3
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic              pulse_i,
  input logic              mod1_o,
  input logic              mod2_o,
  input logic              div_o,
  input logic [FRAC_W-1:0] acc_o,
  input logic              frac_sel_i
);
  // R2: modulus outputs move only after a sampled prescaler pulse
  a_r2_code_on_pulse: assert property (@(posedge clk_i) disable iff (!rst_n)
    !$past(pulse_i) |-> $stable({mod2_o, mod1_o}));

  // R4: a cycle end is produced by a prescaler pulse
  a_r4_div_from_pulse: assert property (@(posedge clk_i) disable iff (!rst_n)
    div_o |-> $past(pulse_i));

  // R4: every division cycle spans at least two pulses, so div_o is a single clock
  a_r4_div_single: assert property (@(posedge clk_i) disable iff (!rst_n)
    div_o |=> !div_o);

  // R8: after an update the accumulator lies below its modulus
  a_r8_acc_below_mod: assert property (@(posedge clk_i) disable iff (!rst_n)
    div_o |-> ({1'b0, acc_o} < ($past(frac_sel_i) ? 4'd8 : 4'd5)));

  // R10: accumulator holds between cycle ends
  a_r10_acc_stable: assert property (@(posedge clk_i) disable iff (!rst_n)
    !div_o |-> $stable(acc_o));
endmodule

bind mmdiv_ctrl mmdiv_chk #(.FRAC_W(FRAC_W)) chk_i (
  .clk_i     (clk_i),
  .rst_n     (rst_sync_n),
  .pulse_i   (pulse_i),
  .mod1_o    (mod1_o),
  .mod2_o    (mod2_o),
  .div_o     (div_o),
  .acc_o     (acc_o),
  .frac_sel_i(frac_sel_i)
);

// File: tb/mmdiv_ctrl_tb_top.sv
`timescale 1ns/1ps
module mmdiv_ctrl_tb_top;

  typedef struct {
    logic [1:0] code;
    bit         fin;
    logic [2:0] acc;
    string      tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pls = 1'b0;
  logic [11:0] n1 = 12'd3;
  logic [7:0]  n2 = 8'd2;
  logic [3:0]  s3 = 4'd0;
  logic [3:0]  s4 = 4'd0;
  logic [1:0]  nmod = 2'b00;
  logic [2:0]  finc = 3'd0;
  logic        fsel = 1'b1;
  logic        mod1, mod2, divp;
  logic [2:0]  acc;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  item_t q[$];

  // requirement-level model state
  int mph, mcnt, macc;
  bit mext;

  always #10 clk = ~clk;

  mmdiv_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pulse_i(pls),
    .n1_i(n1), .n2_i(n2), .sum3_i(s3), .sum4_i(s4), .nmod_i(nmod),
    .frac_inc_i(finc), .frac_sel_i(fsel),
    .mod1_o(mod1), .mod2_o(mod2), .div_o(divp), .acc_o(acc)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] code_of(int ph, bit ext);
    if (ph == 1) return ext ? 2'b00 : 2'b01;
    if (ph == 2) return 2'b00;
    if (ph == 3) return 2'b10;
    return 2'b11;
  endfunction

  task automatic model_step(output logic [1:0] code, output bit fin);
    bit two = (nmod == 2'b00) || (nmod == 2'b11);
    bit hit;
    int s, qm;
    code = code_of(mph, mext);
    fin  = 0;
    if (mph == 1) begin
      mext = 0;
      mcnt--;
      if (mcnt == 0) mph = 2;
    end else begin
      mcnt++;
      if (mph == 2) begin
        hit = two ? ((mcnt % 256) == int'(n2)) : ((mcnt % 16) == int'(n2[3:0]));
        if (hit) begin if (two) fin = 1; else mph = 3; end
      end else if (mph == 3) begin
        if ((mcnt % 16) == int'(s3)) begin if (nmod == 2'b01) fin = 1; else mph = 4; end
      end else begin
        if ((mcnt % 16) == int'(s4)) fin = 1;
      end
    end
    if (fin) begin
      mph  = 1;
      mcnt = int'(n1);
      qm   = fsel ? 8 : 5;
      s    = macc + int'(finc);
      mext = (s >= qm);
      if (s >= qm) s -= qm;
      if (s >= qm) s -= qm;
      macc = s;
    end
  endtask

  // monitor: pops one expected item per prescaler pulse
  initial begin
    item_t it;
    forever begin
      @(negedge clk); #2;
      if (pls) begin
        it = q.pop_front();
        chk({mod2, mod1} == it.code, {it.tag, " R2"}, "mod code", {mod2, mod1}, it.code);
        @(negedge clk); #2;
        chk(divp == it.fin, {it.tag, " R4"}, "div pulse", divp, it.fin);
        chk(acc == it.acc, {it.tag, " R10"}, "acc", acc, it.acc);
      end
    end
  end

  task automatic do_reset(logic [11:0] a, logic [7:0] b, logic [3:0] c, logic [3:0] d,
                          logic [1:0] m, logic [2:0] f, logic fs);
    @(negedge clk);
    rst_n = 1'b0;
    n1 = a; n2 = b; s3 = c; s4 = d; nmod = m; finc = f; fsel = fs;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    chk({mod2, mod1} == 2'b01, "R1", "reset mod code", {mod2, mod1}, 1);
    chk(divp == 1'b0, "R1", "reset div", divp, 0);
    chk(acc == 3'd0, "R1", "reset acc", acc, 0);
    mph = 1; mcnt = int'(a); macc = 0; mext = 0;
  endtask

  // driver: one pulse every two clocks, expected item pushed per pulse
  task automatic run_cycles(int k, string tag);
    int nd = 0;
    logic [1:0] c;
    bit f;
    while (nd < k) begin
      @(negedge clk);
      model_step(c, f);
      q.push_back('{c, f, 3'(macc), tag});
      pls = 1'b1;
      @(negedge clk);
      pls = 1'b0;
      if (f) nd++;
    end
    wait (q.size() == 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int exp_acc[8] = '{3, 6, 1, 4, 7, 2, 5, 0};
    // R3 R4: two-modulus, short counts
    do_reset(12'd3, 8'd2, 4'd0, 4'd0, 2'b00, 3'd0, 1'b1);
    run_cycles(3, "R3 R4");
    // R4: spare code 11 behaves as two-modulus, 8-bit R2 count
    do_reset(12'd2, 8'd20, 4'd5, 4'd9, 2'b11, 3'd0, 1'b1);
    run_cycles(2, "R4 code11");
    // R5: three-modulus, N3 = 2
    do_reset(12'd2, 8'd3, 4'd5, 4'd0, 2'b01, 3'd0, 1'b1);
    run_cycles(2, "R5");
    // R6 R7: four-modulus, zero N3 gives 16 R3 steps, N4 = 3
    do_reset(12'd2, 8'd1, 4'd1, 4'd4, 2'b10, 3'd0, 1'b1);
    run_cycles(2, "R6 R7");
    // R7: N2 = 0 in three-modulus mode gives 16 R2 steps
    do_reset(12'd1, 8'd0, 4'd2, 4'd0, 2'b01, 3'd0, 1'b1);
    run_cycles(2, "R7");
    // R8 R9: modulus 8, increment 3, explicit sequence
    do_reset(12'd2, 8'd1, 4'd0, 4'd0, 2'b00, 3'd3, 1'b1);
    for (int i = 0; i < 8; i++) begin
      run_cycles(1, "R8 R9");
      chk(int'(acc) == exp_acc[i], "R8", "mod8 sequence", acc, exp_acc[i]);
    end
    // R8 R9: modulus 5, increment 2
    do_reset(12'd3, 8'd2, 4'd0, 4'd0, 2'b00, 3'd2, 1'b0);
    run_cycles(6, "R8 R9 mod5");
    // R8: increment above modulus 5 needs double reduction
    do_reset(12'd1, 8'd1, 4'd0, 4'd0, 2'b00, 3'd7, 1'b0);
    run_cycles(4, "R8 inc7");
    chk(int'(acc) == macc, "R8", "inc7 final acc", acc, macc);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule